// File: doc/BRIEF.md
# UART Receive Pop and Interrupt Status Controller

This block sits in a UART register file between the software-visible registers and the receive FIFO storage. It decides when a byte leaves the receive FIFO, and it keeps a small set of sticky interrupt flags: CTS change, transmit empty, receive timeout and receive data at threshold. The serial shifter, the baud generator and the FIFO memory stay outside. The block sees them only through single-cycle strobes, a baud tick and the current FIFO fill count.

A mode bit picks one of two behaviours. With the bit clear, a read of the receive buffer also removes the byte, and the interrupt line passes through a request made by the legacy enable logic elsewhere. With the bit set, a read leaves the byte in place and a separate pop write removes it. The interrupt line is then the OR of the status flags masked by an enable register. Software can clear flags by writing ones to a clear port and force them by writing ones to a set port.

Top module: `rxirq_ctrl`

## Requirements
- R1: After reset, the mode bit is 0, every status bit is 0 and the enable register is 0.
- R2: With the mode bit at 0, `rbr_rd` with a non-zero `rx_count` raises `fifo_pop` in the same cycle, and `pop_wr` has no effect on `fifo_pop`.
- R3: With the mode bit at 1, `rbr_rd` never raises `fifo_pop`, and `pop_wr` with a non-zero `rx_count` raises it in the same cycle. In both modes, no pop is issued while `rx_count` is 0.
- R4: With the mode bit at 0, `irq` equals `legacy_irq`. With the mode bit at 1, `irq` is the OR over all bits of (`status` AND enable register). The enable register uses the same bit positions as `status`.
- R5: Status bit 0 (CTS change) is set at the third rising clock edge after `cts_in` changes level: two synchronizer flops followed by an edge detector.
- R6: Status bit 4 (transmit empty) is set by `tx_empty_evt` and cleared by `thr_wr`.
- R7: Status bit 5 (receive timeout) is set after 40 consecutive `baud_tick` cycles (4 characters of 10 bit times) with a non-zero `rx_count` and no arrival and no pop. It is not set after 39 such cycles, and never while `rx_count` is 0.
- R8: Status bit 5 is cleared by a received character (`rx_char`), by a pop, or by a clear write with bit 5 set.
- R9: Status bit 6 (data at threshold) is set when an `rx_char` makes (`rx_count`+1) reach or pass the threshold. It is cleared when a pop makes (`rx_count`-1) fall below it. The threshold is 1 when `fifo_en` is 0. When `fifo_en` is 1, `trig_sel` picks it: 00→1, 01→4, 10→8, 11→14.
- R10: A `set_wr` sets every implemented status bit (0, 4, 5, 6) whose `set_data` bit is 1. A `clr_wr` clears every implemented bit whose `clr_data` bit is 1. When a set and a clear reach the same bit in the same cycle, the set wins.
- R11: Status bits 1, 2, 3 and 7 always read 0, whatever is written to the set port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Write strobe for the mode bit |
| mode_wdata | input | 1 | New mode value (1 = explicit pop) |
| fifo_en | input | 1 | FIFOs enabled |
| trig_sel | input | 2 | Receive threshold select in FIFO mode |
| rbr_rd | input | 1 | Receive buffer read strobe |
| pop_wr | input | 1 | Pop register write strobe |
| rx_char | input | 1 | A character was received this cycle |
| rx_count | input | 5 | Current receive FIFO fill count |
| baud_tick | input | 1 | One-bit-time tick |
| cts_in | input | 1 | Asynchronous CTS line |
| thr_wr | input | 1 | Transmit holding register write strobe |
| tx_empty_evt | input | 1 | Transmit holding register or FIFO went empty |
| set_wr | input | 1 | Set-register write strobe |
| set_data | input | 8 | Ones force status bits |
| clr_wr | input | 1 | Clear-register write strobe |
| clr_data | input | 8 | Ones clear status bits |
| inte_wr | input | 1 | Enable register write strobe |
| inte_data | input | 8 | New enable value |
| legacy_irq | input | 1 | Request from the legacy enable logic |
| fifo_pop | output | 1 | Remove one byte from the receive FIFO |
| status | output | 8 | Interrupt status flags |
| irq | output | 1 | Interrupt request |

## Verification
The receive timeout is the hardest state to reach. It needs 40 ticks in a row with a non-empty FIFO and no arrival or pop, and random strobes almost never leave that much quiet. Directed runs count exactly 39 and 40 ticks, then rearm the timeout after an arrival, a pop and a clear write. The random phase sets aside a quiet window in every 500 cycles in which only ticks are driven, so the timeout also fires under random FIFO fill levels and modes.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
   localparam int BIT_CTS = 0;
   localparam int BIT_TXE = 4;
   localparam int BIT_RTO = 5;
   localparam int BIT_RDA = 6;
   localparam int MIN_STAT_W = 7;
   localparam int MAX_THRESH = 14;

   function automatic int rx_threshold(input logic fifo_on, input logic [1:0] sel);
      int t;
      if (!fifo_on) t = 1;
      else begin
         case (sel)
            2'b00:   t = 1;
            2'b01:   t = 4;
            2'b10:   t = 8;
            default: t = MAX_THRESH;
         endcase
      end
      return t;
   endfunction
endpackage

// File: rtl/rxirq_cts_sync.sv
module rxirq_cts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic changed
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rxirq_cts_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], line_in};
   end

   assign changed = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/rxirq_timeout.sv
module rxirq_timeout #(
   parameter int TICKS = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic activity,
   input  logic nonempty,
   output logic fire
);
   localparam int TW = $clog2(TICKS + 1);

   if (TICKS < 2) begin : g_bad_ticks
      $error("rxirq_timeout: TICKS must be at least 2");
   end

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                        cnt <= '0;
      else if (activity || !nonempty)    cnt <= '0;
      else if (tick && cnt != TW'(TICKS)) cnt <= cnt + 1'b1;
   end

   assign fire = tick && (cnt == TW'(TICKS - 1)) && nonempty && !activity;

   // R7: the counter never moves past its limit
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TW'(TICKS));
   // R7: after firing, the window stays saturated until activity or empty
   assert_fire_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (cnt == TW'(TICKS)));
endmodule

// File: rtl/rxirq_status.sv
module rxirq_status #(
   parameter int              W    = 8,
   parameter logic [W-1:0]    IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] q
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (IMPL[i]) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)          q[i] <= 1'b0;
            else if (set_vec[i]) q[i] <= 1'b1;
            else if (clr_vec[i]) q[i] <= 1'b0;
         end
         // R10: a set reaching the bit wins over any clear
         assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> q[i]);
         // R10: a lone clear empties the bit
         assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !q[i]);
      end else begin : g_resv
         assign q[i] = 1'b0;
         // R11: requests on a reserved position leave it at zero
         assert_reserved_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] || clr_vec[i]) |=> !q[i]);
      end
   end
endmodule

// File: rtl/rxirq_ctrl.sv
module rxirq_ctrl #(
   parameter int FIFO_DEPTH  = 16,
   parameter int CHAR_BITS   = 10,
   parameter int TO_CHARS    = 4,
   parameter int STAT_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              mode_wdata,
   input  logic              fifo_en,
   input  logic [1:0]        trig_sel,
   input  logic              rbr_rd,
   input  logic              pop_wr,
   input  logic              rx_char,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic              baud_tick,
   input  logic              cts_in,
   input  logic              thr_wr,
   input  logic              tx_empty_evt,
   input  logic              set_wr,
   input  logic [STAT_W-1:0] set_data,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_data,
   input  logic              inte_wr,
   input  logic [STAT_W-1:0] inte_data,
   input  logic              legacy_irq,
   output logic              fifo_pop,
   output logic [STAT_W-1:0] status,
   output logic              irq
);
   import rxirq_pkg::*;

   localparam int TO_TICKS = CHAR_BITS * TO_CHARS;
   localparam int CW1      = CNT_W + 1;
   localparam logic [STAT_W-1:0] IMPL = STAT_W'((1 << BIT_CTS) | (1 << BIT_TXE) |
                                                (1 << BIT_RTO) | (1 << BIT_RDA));

   if (STAT_W < MIN_STAT_W) begin : g_bad_width
      $error("rxirq_ctrl: STAT_W too small for the flag layout");
   end
   if (FIFO_DEPTH < MAX_THRESH) begin : g_bad_depth
      $error("rxirq_ctrl: FIFO_DEPTH below the largest threshold");
   end

   logic              mode_q;
   logic [STAT_W-1:0] inte_q;
   logic              pop_req, do_pop;
   logic              cts_chg, rto_fire;
   logic [CW1-1:0]    thresh, cnt_up, cnt_dn;
   logic              rda_set, rda_clr;
   logic [STAT_W-1:0] set_vec, clr_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         inte_q <= '0;
      end else begin
         if (mode_wr) mode_q <= mode_wdata;
         if (inte_wr) inte_q <= inte_data & IMPL;
      end
   end

   // pop source follows the mode bit; an empty FIFO is never popped
   assign pop_req  = mode_q ? pop_wr : rbr_rd;
   assign do_pop   = pop_req && (rx_count != '0);
   assign fifo_pop = do_pop;

   rxirq_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (cts_in),
      .changed (cts_chg)
   );

   rxirq_timeout #(.TICKS(TO_TICKS)) u_rto (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .activity (rx_char || do_pop),
      .nonempty (rx_count != '0),
      .fire     (rto_fire)
   );

   assign thresh  = CW1'(rx_threshold(fifo_en, trig_sel));
   assign cnt_up  = {1'b0, rx_count} + 1'b1;
   assign cnt_dn  = {1'b0, rx_count} - 1'b1;
   assign rda_set = rx_char && (cnt_up >= thresh);
   assign rda_clr = do_pop && (cnt_dn < thresh);

   always_comb begin
      set_vec = set_wr ? set_data : '0;
      clr_vec = clr_wr ? clr_data : '0;
      set_vec[BIT_CTS] = set_vec[BIT_CTS] | cts_chg;
      set_vec[BIT_TXE] = set_vec[BIT_TXE] | tx_empty_evt;
      set_vec[BIT_RTO] = set_vec[BIT_RTO] | rto_fire;
      set_vec[BIT_RDA] = set_vec[BIT_RDA] | rda_set;
      clr_vec[BIT_TXE] = clr_vec[BIT_TXE] | thr_wr;
      clr_vec[BIT_RTO] = clr_vec[BIT_RTO] | rx_char | do_pop;
      clr_vec[BIT_RDA] = clr_vec[BIT_RDA] | rda_clr;
   end

   rxirq_status #(.W(STAT_W), .IMPL(IMPL)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .q       (status)
   );

   assign irq = mode_q ? |(status & inte_q) : legacy_irq;

   // R2: in legacy mode only a read can remove a byte
   assert_legacy_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q && !rbr_rd) |-> !fifo_pop);
   // R3: in explicit mode a read alone never removes a byte
   assert_explicit_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q && !pop_wr) |-> !fifo_pop);
   // R7: a timeout rise without a forced set needs a non-empty FIFO
   assert_rto_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status[BIT_RTO]) && !$past(set_wr)) |-> ($past(rx_count) != '0));
   // R9: a threshold rise without a forced set follows an arrival
   assert_rda_arrival_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(status[BIT_RDA]) && !$past(set_wr)) |-> $past(rx_char));
endmodule

// File: tb/sim_rxirq_ctrl.sv
module sim_rxirq_ctrl;
   localparam int D = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 0, mode_wdata = 0, fifo_en = 0;
   logic [1:0] trig_sel = 0;
   logic       rbr_rd = 0, pop_wr = 0, rx_char = 0, baud_tick = 0, cts_in = 0;
   logic [4:0] rx_count = 0;
   logic       thr_wr = 0, tx_empty_evt = 0, set_wr = 0, clr_wr = 0, inte_wr = 0;
   logic [7:0] set_data = 0, clr_data = 0, inte_data = 0;
   logic       legacy_irq = 0;
   logic       fifo_pop, irq;
   logic [7:0] status;

   int checks = 0, errors = 0;
   bit done = 0;

   // bench model state
   logic [2:0] m_sh = 0;
   int         m_cnt = 0, m_tc = 0;
   logic [7:0] m_stat = 0, e_inte = 0;
   logic       e_mode = 0;

   always #5 clk = ~clk;

   rxirq_ctrl u0 (.*);

   function automatic int b_thr(input logic fe, input logic [1:0] sel);
      if (!fe) return 1;
      case (sel)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      mode_wr = 0; rbr_rd = 0; pop_wr = 0; rx_char = 0; baud_tick = 0;
      thr_wr = 0; tx_empty_evt = 0; set_wr = 0; clr_wr = 0; inte_wr = 0;
   endtask

   // one clock: check outputs against the model, then advance the model
   task automatic cyc();
      logic e_pop, chg, fire;
      logic [7:0] sv, cv, ns;
      int thr, nt, nc;
      #1;
      e_pop = (e_mode ? pop_wr : rbr_rd) && (m_cnt != 0);
      chk(e_mode ? "R3 pop strobe" : "R2 pop strobe", fifo_pop, e_pop);
      chk("R4 irq", irq, e_mode ? |(m_stat & e_inte) : legacy_irq);
      chk("R5 cts flag", status[0], m_stat[0]);
      chk("R6 tx empty flag", status[4], m_stat[4]);
      chk("R7 timeout flag", status[5], m_stat[5]);
      chk("R9 threshold flag", status[6], m_stat[6]);
      chk("R11 reserved bits", status & 8'h8E, 0);
      chg  = m_sh[2] ^ m_sh[1];
      fire = baud_tick && (m_tc == 39) && (m_cnt != 0) && !rx_char && !e_pop;
      thr  = b_thr(fifo_en, trig_sel);
      sv = set_wr ? set_data : 8'h00;
      cv = clr_wr ? clr_data : 8'h00;
      if (chg) sv[0] = 1;
      if (tx_empty_evt) sv[4] = 1;
      if (fire) sv[5] = 1;
      if (rx_char && (m_cnt + 1 >= thr)) sv[6] = 1;
      if (thr_wr) cv[4] = 1;
      if (rx_char || e_pop) cv[5] = 1;
      if (e_pop && (m_cnt - 1 < thr)) cv[6] = 1;
      ns = (m_stat | sv) & ~(cv & ~sv) & 8'h71;
      if (rx_char || e_pop || m_cnt == 0) nt = 0;
      else if (baud_tick && m_tc < 40) nt = m_tc + 1;
      else nt = m_tc;
      nc = m_cnt + ((rx_char && m_cnt < D) ? 1 : 0) - (e_pop ? 1 : 0);
      @(posedge clk);
      m_stat = ns; m_tc = nt; m_cnt = nc;
      m_sh = {m_sh[1:0], cts_in};
      if (mode_wr) e_mode = mode_wdata;
      if (inte_wr) e_inte = inte_data & 8'h71;
      @(negedge clk);
      rx_count = 5'(m_cnt);
      idle();
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin baud_tick = 1; cyc(); end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      chk("R1 reset status", status, 0);
      chk("R1 reset irq legacy", irq, 0);
      rst_n = 1;
      rbr_rd = 1;
      #1 chk("R3 no pop when empty", fifo_pop, 0);
      cyc();

      // R2: legacy read pops, pop write ignored
      rx_char = 1; cyc(); rx_char = 1; cyc();
      pop_wr = 1; #1 chk("R2 pop write ignored", fifo_pop, 0); cyc();
      rbr_rd = 1; #1 chk("R2 read pops", fifo_pop, 1); cyc();

      // R7 and R8: timeout window and its clear paths
      ticks(39); chk("R7 not after 39 ticks", status[5], 0);
      ticks(1);  chk("R7 after 40 ticks", status[5], 1);
      rx_char = 1; cyc(); chk("R8 arrival clears", status[5], 0);
      ticks(40); chk("R7 rearmed", status[5], 1);
      rbr_rd = 1; cyc(); chk("R8 pop clears", status[5], 0);
      ticks(40);
      clr_wr = 1; clr_data = 8'h20; cyc(); chk("R8 clear write", status[5], 0);
      while (m_cnt != 0) begin rbr_rd = 1; cyc(); end
      ticks(45); chk("R7 empty never times out", status[5], 0);

      // R5: CTS edge at the third clock edge
      cts_in = 1; cyc(); cyc(); chk("R5 not after two edges", status[0], 0);
      cyc(); chk("R5 after third edge", status[0], 1);

      // R10: set wins over clear, lone clear works
      clr_wr = 1; clr_data = 8'h01; set_wr = 1; set_data = 8'h01; cyc();
      chk("R10 set wins", status[0], 1);
      clr_wr = 1; clr_data = 8'h01; cyc(); chk("R10 clear", status[0], 0);

      // R6: transmit empty flag
      tx_empty_evt = 1; cyc(); chk("R6 empty sets", status[4], 1);
      thr_wr = 1; cyc(); chk("R6 holding write clears", status[4], 0);
      set_wr = 1; set_data = 8'h10; cyc(); chk("R6 forced", status[4], 1);
      thr_wr = 1; tx_empty_evt = 1; cyc(); chk("R10 event beats write", status[4], 1);

      // R11: reserved bits ignore set writes
      set_wr = 1; set_data = 8'hFF; cyc(); chk("R11 set all", status, 8'h71);
      clr_wr = 1; clr_data = 8'hFF; cyc(); chk("R10 clear all", status, 8'h00);

      // R3 and R4: explicit mode
      mode_wr = 1; mode_wdata = 1; cyc();
      rx_char = 1; cyc();
      rbr_rd = 1; #1 chk("R3 read keeps byte", fifo_pop, 0); cyc();
      legacy_irq = 1; #1 chk("R4 explicit ignores legacy", irq, 0); cyc();
      inte_wr = 1; inte_data = 8'hFF; cyc();
      chk("R4 enabled flag raises irq", irq, 1);
      pop_wr = 1; #1 chk("R3 pop write pops", fifo_pop, 1); cyc();
      chk("R4 irq drops with flag", irq, 0);
      legacy_irq = 0;

      // R9: threshold 14 in FIFO mode
      fifo_en = 1; trig_sel = 2'b11;
      for (int k = 0; k < 13; k++) begin rx_char = 1; cyc(); end
      chk("R9 13 below threshold", status[6], 0);
      rx_char = 1; cyc(); chk("R9 14 reaches threshold", status[6], 1);
      pop_wr = 1; cyc(); chk("R9 pop below threshold clears", status[6], 0);
      trig_sel = 2'b01;
      rx_char = 1; cyc(); chk("R9 level 4 already passed", status[6], 1);

      // random phase with quiet windows for the timeout
      for (int i = 0; i < 4000; i++) begin
         bit quiet;
         quiet = (i % 500) >= 400;
         baud_tick = ($urandom_range(1) == 1);
         legacy_irq = ($urandom_range(3) == 0);
         if (!quiet) begin
            rx_char = ($urandom_range(9) < 3);
            rbr_rd  = ($urandom_range(9) < 2);
            pop_wr  = ($urandom_range(9) < 2);
            if ($urandom_range(49) == 0) cts_in = ~cts_in;
            thr_wr       = ($urandom_range(19) == 0);
            tx_empty_evt = ($urandom_range(19) == 0);
            set_wr = ($urandom_range(29) == 0); set_data = 8'($urandom);
            clr_wr = ($urandom_range(19) == 0); clr_data = 8'($urandom);
            inte_wr = ($urandom_range(49) == 0); inte_data = 8'($urandom);
            mode_wr = ($urandom_range(99) == 0); mode_wdata = 1'($urandom);
            if ($urandom_range(99) == 0) begin
               fifo_en = 1'($urandom); trig_sel = 2'($urandom);
            end
         end
         cyc();
      end

      done = 1;
      summary();
   end
endmodule